// File: doc/BRIEF.md
# Bit-Count SPI Transaction Engine

This block is a single-chip-select SPI master controlled through a small 32-bit register port. Software loads an opcode byte and chooses how many bits go out on MOSI and how many come back on MISO. It then writes the start bit and polls the busy flag until it clears. One start produces a phase-sequenced transfer: every outgoing bit is sent first, most significant bit first, taken from the opcode byte. The incoming bits follow and are shifted into a read-data register.

The serial clock runs at the system clock divided by (divider + 2). It idles low. Data is launched while SCK is low (at the falling edge) and sampled on the rising edge. Chip select is driven directly from a software-owned polarity bit, so a host can keep the device selected across several transfers. The counts, the opcode and the divider are captured when a transfer starts, so the host may prepare the next transfer while the current one runs.

Top module: `spi_bitcount_master`

## Requirements
- R1: After reset `cs_n` is 1, `sck` and `mosi` are 0, and every register reads 0, including busy (bit 16 at offset 0x00) and the read data (offset 0x08).
- R2: Reads return the opcode in bits 7:0 of 0x04 and the divider in bits 27:16 of 0x28. Offset 0x2C returns the transmit count in bits 29:24 and the receive count in bits 20:12. Offset 0x38 returns the select bit in bit 0, and offset 0x00 returns busy in bit 16. Every other bit reads 0, and the start bit (bit 8 of 0x00) always reads 0.
- R3: `cs_n` is the inverse of bit 0 of offset 0x38. It follows a write to that bit on the next cycle.
- R4: Writing offset 0x00 with bit 8 set while idle makes busy read 1 from the next cycle. Busy then stays 1 for exactly N*P+1 cycles, where N = transmit count + receive count and P = divider + 2.
- R5: A start with both counts zero holds busy for one cycle and produces no SCK edge.
- R6: SCK is low whenever no counted bit is in progress. Each bit lasts P cycles, and SCK is high for floor(P/2) of them. The first rising edge comes P - floor(P/2) cycles after busy rises.
- R7: During the first (transmit count) bits, MOSI carries opcode bit 7, then bit 6, and so on. Bits beyond the eighth are 0. MOSI is 0 in the receive phase and when idle, and it changes only while SCK is low.
- R8: During the last (receive count) bits, MISO is sampled on each SCK rising edge and shifted into bit 0 of the 32-bit read data, with older bits moving up. The read data is not cleared by a start.
- R9: A start written while busy reads 1 is ignored, including one written in the final busy cycle. Busy then falls on schedule and no further bits follow.
- R10: Writes to the opcode, count or divider registers during a transfer do not change that transfer's bits, length or timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte offset for both write and read |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| sck | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low chip select |

## Verification
Two things can land in the same cycle. One is a host write of start (or of the count, opcode or divider) against a transfer that is still running. The other is the engine's own final busy cycle, in which it retires the transfer. The bench provokes both by issuing these writes at a chosen busy cycle: the last busy cycle, and cycles early in the transfer. It judges them by the busy length, the count of SCK rising edges, the MOSI bit values and the read data, all compared against values computed from the counts captured at start. Random transfers with varied counts, dividers and MISO patterns surround these directed cases.

// File: rtl/spi_bc_pkg.sv
// Shared offsets, field positions and the write-request type for the
// bit-count SPI engine. Assumes a 32-bit register port with byte offsets.
package spi_bc_pkg;
    localparam int REG_ADDR_W = 8;
    localparam int DATA_W     = 32;

    localparam logic [REG_ADDR_W-1:0] OFS_XFER   = 8'h00;
    localparam logic [REG_ADDR_W-1:0] OFS_OPCODE = 8'h04;
    localparam logic [REG_ADDR_W-1:0] OFS_RXDATA = 8'h08;
    localparam logic [REG_ADDR_W-1:0] OFS_CONFIG = 8'h28;
    localparam logic [REG_ADDR_W-1:0] OFS_COUNT  = 8'h2C;
    localparam logic [REG_ADDR_W-1:0] OFS_CSPOL  = 8'h38;

    localparam int BIT_BUSY  = 16;
    localparam int BIT_START = 8;
    localparam int DIV_LSB   = 16;
    localparam int TXCNT_LSB = 24;
    localparam int RXCNT_LSB = 12;

    typedef struct packed {
        logic                  en;
        logic [REG_ADDR_W-1:0] addr;
        logic [DATA_W-1:0]     data;
    } reg_wr_t;
endpackage

// File: rtl/spi_bc_regs.sv
// Register file and read multiplexer. Holds opcode, divider, bit counts
// and chip-select polarity; decodes the self-clearing start request.
// Assumes full-word writes; reads are combinational from the address.
module spi_bc_regs
    import spi_bc_pkg::*;
#(
    parameter int DIV_W   = 12,
    parameter int TXCNT_W = 6,
    parameter int RXCNT_W = 9,
    parameter int OP_W    = 8,
    parameter int RXD_W   = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  reg_wr_t               wr,
    input  logic [REG_ADDR_W-1:0] rd_addr,
    input  logic                  busy,
    input  logic [RXD_W-1:0]      rx_data,
    output logic [OP_W-1:0]       opcode,
    output logic [DIV_W-1:0]      div,
    output logic [TXCNT_W-1:0]    tx_cnt,
    output logic [RXCNT_W-1:0]    rx_cnt,
    output logic                  cs_pol,
    output logic                  start_req,
    output logic [DATA_W-1:0]     rdata
);
    logic unused_wr_bits;
    assign unused_wr_bits = ^wr.data;

    // Start is a pulse: nothing stores it, so it reads back as zero.
    assign start_req = wr.en && (wr.addr == OFS_XFER) && wr.data[BIT_START];

    // Software-visible configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opcode <= '0;
            div    <= '0;
            tx_cnt <= '0;
            rx_cnt <= '0;
            cs_pol <= 1'b0;
        end else if (wr.en) begin
            case (wr.addr)
                OFS_OPCODE: opcode <= wr.data[OP_W-1:0];
                OFS_CONFIG: div    <= wr.data[DIV_LSB +: DIV_W];
                OFS_COUNT: begin
                    tx_cnt <= wr.data[TXCNT_LSB +: TXCNT_W];
                    rx_cnt <= wr.data[RXCNT_LSB +: RXCNT_W];
                end
                OFS_CSPOL:  cs_pol <= wr.data[0];
                default: ;
            endcase
        end
    end

    // Read multiplexer; unmapped bits and offsets return zero.
    always_comb begin
        rdata = '0;
        case (rd_addr)
            OFS_XFER:   rdata[BIT_BUSY]               = busy;
            OFS_OPCODE: rdata[OP_W-1:0]               = opcode;
            OFS_RXDATA: rdata[RXD_W-1:0]              = rx_data;
            OFS_CONFIG: rdata[DIV_LSB +: DIV_W]       = div;
            OFS_COUNT: begin
                rdata[TXCNT_LSB +: TXCNT_W] = tx_cnt;
                rdata[RXCNT_LSB +: RXCNT_W] = rx_cnt;
            end
            OFS_CSPOL:  rdata[0]                      = cs_pol;
            default: ;
        endcase
    end
endmodule

// File: rtl/spi_bc_clkgen.sv
// Bit-period timer. While run is high it counts P = div + 2 cycles per
// bit: SCK is low for the first P - floor(P/2) cycles and high for the
// rest. It flags the cycle before the rising edge (sample) and the last
// cycle of each bit (bit_end). Assumes div is stable while run is high.
module spi_bc_clkgen #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             sck,
    output logic             sample_stb,
    output logic             bit_end
);
    localparam int CNT_W = DIV_W + 1;

    logic [CNT_W-1:0] period;
    logic [CNT_W-1:0] high_len;
    logic [CNT_W-1:0] low_len;
    logic [CNT_W-1:0] cnt;

    // Derive phase lengths from the captured divider.
    always_comb begin
        period   = CNT_W'(div) + CNT_W'(2);
        high_len = period >> 1;
        low_len  = period - high_len;
    end

    assign bit_end    = run && (cnt == period - CNT_W'(1));
    assign sample_stb = run && (cnt == low_len - CNT_W'(1));
    assign sck        = run && (cnt >= low_len);

    // Position inside the current bit; held at zero while idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || bit_end) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/spi_bc_sequencer.sv
// Transaction sequencer. Captures counts, opcode and divider on start,
// sends the transmit bits MSB first, then shifts received bits into the
// read-data register. Busy covers all bits plus one retire cycle.
// Assumes start_req is ignored while busy.
module spi_bc_sequencer #(
    parameter int DIV_W   = 12,
    parameter int TXCNT_W = 6,
    parameter int RXCNT_W = 9,
    parameter int OP_W    = 8,
    parameter int RXD_W   = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_req,
    input  logic [OP_W-1:0]    opcode,
    input  logic [DIV_W-1:0]   div,
    input  logic [TXCNT_W-1:0] tx_cnt,
    input  logic [RXCNT_W-1:0] rx_cnt,
    input  logic               miso,
    input  logic               sample_stb,
    input  logic               bit_end,
    output logic               busy,
    output logic               run,
    output logic               tx_phase,
    output logic               mosi,
    output logic [DIV_W-1:0]   div_lat,
    output logic [RXD_W-1:0]   rx_data
);
    logic [TXCNT_W-1:0] tx_left;
    logic [RXCNT_W-1:0] rx_left;
    logic [OP_W-1:0]    tx_sh;

    assign tx_phase = busy && (tx_left != '0);
    assign run      = busy && ((tx_left != '0) || (rx_left != '0));
    assign mosi     = tx_phase && tx_sh[OP_W-1];

    // Transaction state: capture on start, count bits down, retire.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            tx_left <= '0;
            rx_left <= '0;
            tx_sh   <= '0;
            div_lat <= '0;
        end else if (!busy) begin
            if (start_req) begin
                busy    <= 1'b1;
                tx_left <= tx_cnt;
                rx_left <= rx_cnt;
                tx_sh   <= opcode;
                div_lat <= div;
            end
        end else if (!run) begin
            busy <= 1'b0;
        end else if (bit_end) begin
            if (tx_left != '0) begin
                tx_left <= tx_left - 1'b1;
                tx_sh   <= {tx_sh[OP_W-2:0], 1'b0};
            end else begin
                rx_left <= rx_left - 1'b1;
            end
        end
    end

    // Receive shifter: one MISO bit per rising edge in the receive phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data <= '0;
        end else if (sample_stb && !tx_phase) begin
            rx_data <= {rx_data[RXD_W-2:0], miso};
        end
    end
endmodule

// File: rtl/spi_bitcount_master.sv
// Top of the bit-count SPI engine: register port, sequencer and bit
// timer, plus the chip-select drive. Assumes a single chip select.
module spi_bitcount_master
    import spi_bc_pkg::*;
#(
    parameter int DIV_W   = 12,
    parameter int TXCNT_W = 6,
    parameter int RXCNT_W = 9,
    parameter int OP_W    = 8,
    parameter int RXD_W   = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_we,
    input  logic [REG_ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0]     reg_wdata,
    output logic [DATA_W-1:0]     reg_rdata,
    output logic                  sck,
    output logic                  mosi,
    input  logic                  miso,
    output logic                  cs_n
);
    reg_wr_t            wr;
    logic [OP_W-1:0]    opcode;
    logic [DIV_W-1:0]   div;
    logic [DIV_W-1:0]   div_lat;
    logic [TXCNT_W-1:0] tx_cnt;
    logic [RXCNT_W-1:0] rx_cnt;
    logic               cs_pol;
    logic               start_req;
    logic               busy;
    logic               run;
    logic               tx_phase;
    logic               sample_stb;
    logic               bit_end;
    logic [RXD_W-1:0]   rx_data;

    // Bundle the write port for the register file.
    always_comb begin
        wr.en   = reg_we;
        wr.addr = reg_addr;
        wr.data = reg_wdata;
    end

    assign cs_n = !cs_pol;

    spi_bc_regs #(
        .DIV_W(DIV_W), .TXCNT_W(TXCNT_W), .RXCNT_W(RXCNT_W),
        .OP_W(OP_W), .RXD_W(RXD_W)
    ) i_regs (
        .clk(clk), .rst_n(rst_n), .wr(wr), .rd_addr(reg_addr),
        .busy(busy), .rx_data(rx_data), .opcode(opcode), .div(div),
        .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .cs_pol(cs_pol),
        .start_req(start_req), .rdata(reg_rdata)
    );

    spi_bc_sequencer #(
        .DIV_W(DIV_W), .TXCNT_W(TXCNT_W), .RXCNT_W(RXCNT_W),
        .OP_W(OP_W), .RXD_W(RXD_W)
    ) i_seq (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .opcode(opcode),
        .div(div), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .miso(miso),
        .sample_stb(sample_stb), .bit_end(bit_end), .busy(busy),
        .run(run), .tx_phase(tx_phase), .mosi(mosi), .div_lat(div_lat),
        .rx_data(rx_data)
    );

    spi_bc_clkgen #(
        .DIV_W(DIV_W)
    ) i_clk (
        .clk(clk), .rst_n(rst_n), .run(run), .div(div_lat),
        .sck(sck), .sample_stb(sample_stb), .bit_end(bit_end)
    );
endmodule

// File: rtl/spi_bc_checker.sv
// Protocol checker for the bit-count SPI engine, bound to the top.
// Assumes synchronous active-low reset on rst_n.
module spi_bc_checker
    import spi_bc_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  reg_we,
    input logic [REG_ADDR_W-1:0] reg_addr,
    input logic                  wr_start_bit,
    input logic                  wr_cs_bit,
    input logic                  sck,
    input logic                  mosi,
    input logic                  cs_n,
    input logic                  busy,
    input logic                  run,
    input logic                  tx_phase
);
    logic start_wr;
    assign start_wr = reg_we && (reg_addr == OFS_XFER) && wr_start_bit;

    p_sck_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !sck);

    p_mosi_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_phase |-> !mosi);

    p_mosi_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sck && $past(sck)) |-> $stable(mosi));

    p_cs_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == OFS_CSPOL) |=> (cs_n == !$past(wr_cs_bit)));

    p_start_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (start_wr && !busy) |=> busy);

    p_tail_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start_wr && busy && !run) |=> !busy);
endmodule

bind spi_bitcount_master spi_bc_checker i_chk (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .wr_start_bit(reg_wdata[spi_bc_pkg::BIT_START]), .wr_cs_bit(reg_wdata[0]),
    .sck(sck), .mosi(mosi), .cs_n(cs_n), .busy(busy), .run(run),
    .tx_phase(tx_phase)
);

// File: tb/test_spi_bitcount_master.sv
module test_spi_bitcount_master;
    import spi_bc_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic        sck, mosi, cs_n;
    logic        miso = 1'b0;

    int          n_chk = 0;
    int          n_fail = 0;
    logic [31:0] rxm = 32'h0;
    logic        cur_miso = 1'b0;

    always #2 clk = ~clk;

    spi_bitcount_master i_spi_bitcount_master (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sck(sck),
        .mosi(mosi), .miso(miso), .cs_n(cs_n)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int exp_busy(input int tx, input int rx, input int dv);
        return (tx + rx) * (dv + 2) + 1;
    endfunction

    function automatic logic exp_tx_bit(input logic [7:0] op, input int k);
        return (k < 8) ? op[7-k] : 1'b0;
    endfunction

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        #1 reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b0; reg_addr = a;
        #1 d = reg_rdata;
    endtask

    // One transfer: program, start, observe every cycle, then judge.
    task automatic run_txn(input int tx, input int rx, input int dv, input logic [7:0] op,
                           input int mid_idx, input logic [7:0] mid_a, input logic [31:0] mid_d,
                           input string tag);
        int p = dv + 2;
        int h = p / 2;
        int l = p - h;
        int eb = exp_busy(tx, rx, dv);
        int busy_n = 0, rises = 0, idx = 0, last_rise = 0, hi = 0;
        int mosi_bad = 0, per_bad = 0, hi_bad = 0;
        logic prev = 1'b0, s;
        logic [31:0] d;
        wr(OFS_CONFIG, 32'(dv) << 16);
        wr(OFS_OPCODE, {24'h0, op});
        wr(OFS_COUNT, (32'(tx) << 24) | (32'(rx) << 12));
        cur_miso = 1'($urandom % 2);
        miso = cur_miso;
        @(negedge clk);
        reg_we = 1'b1; reg_addr = OFS_XFER; reg_wdata = 32'h100;
        while (idx < 6000) begin
            @(negedge clk);
            reg_we = 1'b0; reg_addr = OFS_XFER;
            #1 s = sck;
            if (s && !prev) begin
                if (rises == 0) begin
                    if (idx != l) per_bad++;
                end else if (idx - last_rise != p) per_bad++;
                last_rise = idx;
                if (rises < tx) begin
                    if (mosi !== exp_tx_bit(op, rises)) mosi_bad++;
                end else begin
                    if (mosi !== 1'b0) mosi_bad++;
                    rxm = {rxm[30:0], cur_miso};
                    cur_miso = 1'($urandom % 2);
                    miso = cur_miso;
                end
                rises++;
                hi = 0;
            end
            if (s) hi++;
            if (!s && prev && hi != h) hi_bad++;
            prev = s;
            if (!reg_rdata[16]) break;
            busy_n++;
            if (busy_n - 1 == mid_idx) begin
                reg_we = 1'b1; reg_addr = mid_a; reg_wdata = mid_d;
            end
            idx++;
        end
        check(busy_n == eb, {"R4 busy length ", tag}, busy_n, eb);
        check(rises == tx + rx, {"R5/R6 rising edge count ", tag}, rises, tx + rx);
        check(per_bad == 0 && hi_bad == 0, {"R6 bit timing ", tag}, per_bad + hi_bad, 0);
        check(mosi_bad == 0, {"R7 mosi bits ", tag}, mosi_bad, 0);
        check(sck == 1'b0 && mosi == 1'b0, {"R6 R7 idle lines ", tag}, {sck, mosi}, 0);
        rd(OFS_RXDATA, d);
        check(d == rxm, {"R8 read data ", tag}, d, rxm);
    endtask

    initial begin
        #(4 * 190000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(cs_n == 1'b1 && sck == 1'b0 && mosi == 1'b0, "R1 lines in reset", {cs_n, sck, mosi}, 3'b100);
        rst_n = 1'b1;
        rd(OFS_XFER, d);   check(d == 0, "R1 transaction reg", d, 0);
        rd(OFS_RXDATA, d); check(d == 0, "R1 read data", d, 0);
        rd(OFS_COUNT, d);  check(d == 0, "R1 count reg", d, 0);
        rd(OFS_CONFIG, d); check(d == 0, "R1 config reg", d, 0);
        check(cs_n == 1'b1, "R1 cs_n after reset", cs_n, 1);

        // R2 field placement with all-ones writes
        wr(OFS_CONFIG, 32'hFFFF_FFFF); rd(OFS_CONFIG, d);
        check(d == 32'h0FFF_0000, "R2 config field", d, 32'h0FFF_0000);
        wr(OFS_COUNT, 32'hFFFF_FFFF); rd(OFS_COUNT, d);
        check(d == 32'h3F1F_F000, "R2 count fields", d, 32'h3F1F_F000);
        wr(OFS_OPCODE, 32'hFFFF_FFFF); rd(OFS_OPCODE, d);
        check(d == 32'hFF, "R2 opcode field", d, 32'hFF);
        wr(OFS_XFER, 32'hFFFF_FEFF); rd(OFS_XFER, d);
        check(d == 0, "R2 transaction reg without start", d, 0);

        // R3 chip select follows polarity bit
        wr(OFS_CSPOL, 32'hFFFF_FFFF);
        check(cs_n == 1'b0, "R3 cs asserted", cs_n, 0);
        rd(OFS_CSPOL, d); check(d == 1, "R2 polarity readback", d, 1);
        wr(OFS_CSPOL, 32'h0);
        check(cs_n == 1'b1, "R3 cs released", cs_n, 1);
        wr(OFS_CSPOL, 32'h1);

        // Directed transfers
        run_txn(8, 0, 13, 8'hA5, -1, 8'h0, 32'h0, "R7 write byte div13");
        run_txn(0, 8, 0, 8'h00, -1, 8'h0, 32'h0, "R8 read byte");
        run_txn(0, 0, 3, 8'hFF, -1, 8'h0, 32'h0, "R5 zero counts");
        run_txn(12, 3, 1, 8'hFF, -1, 8'h0, 32'h0, "R7 zero fill past byte");
        run_txn(8, 0, 0, 8'h3C, exp_busy(8, 0, 0) - 1, OFS_XFER, 32'h100, "R9 start in last busy cycle");
        run_txn(4, 4, 2, 8'h96, 3, OFS_XFER, 32'h100, "R9 start mid transfer");
        run_txn(8, 4, 2, 8'hC3, 2, OFS_COUNT, 32'h0, "R10 count write during transfer");
        run_txn(8, 4, 2, 8'hC3, 2, OFS_OPCODE, 32'h0, "R10 opcode write during transfer");
        run_txn(6, 6, 1, 8'h5A, 4, OFS_CONFIG, 32'h00FF_0000, "R10 divider write during transfer");

        // Random transfers with occasional writes landing mid-transfer
        for (int i = 0; i < 25; i++) begin
            int tx = $urandom_range(0, 16);
            int rx = $urandom_range(0, 40);
            int dv = $urandom_range(0, 5);
            logic [7:0] op = 8'($urandom);
            int mi = -1;
            logic [7:0] ma = OFS_XFER;
            if ($urandom_range(0, 2) == 0) begin
                mi = $urandom_range(0, exp_busy(tx, rx, dv) - 1);
                case ($urandom_range(0, 3))
                    0: ma = OFS_XFER;
                    1: ma = OFS_COUNT;
                    2: ma = OFS_OPCODE;
                    default: ma = OFS_CONFIG;
                endcase
            end
            run_txn(tx, rx, dv, op, mi, ma, $urandom, "R4 R8 R9 R10 random");
        end

        rd(OFS_XFER, d);
        check(d == 0, "R4 idle after all transfers", d, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule